// File: doc/BRIEF.md
# Paged Processor Register Interface

This block connects an asynchronous 8-bit processor bus to the memories of a time-slot switch. The bus has an active-low chip select, an active-high data strobe, a read/write line (1 = read), six address lines and an active-low acknowledge. With address bit 5 low, the bus reaches a single mode register. With address bit 5 high, the bus reaches a 32-byte page. The mode register chooses which memory the page maps to (data memory, connection low byte or connection high byte) and which of four streams it covers. Six address lines thus reach 384 bytes.

The bus pins are brought into the serial clock domain through a multi-stage synchronizer. A new access starts on a fresh rising edge of the synchronized strobe. A mode register write is acknowledged combinationally from the pins. Every other access is acknowledged only after the access has been handled in the serial clock domain. A page access also waits for the processor slot of the memory time-multiplexing, which the `proc_slot` input marks. Memory traffic leaves the block on a one-cycle request port, and read data comes back in the same cycle. Bit 7 of the mode register selects a split mode: page reads then come from the data memory and page writes go to the connection low byte.

Top module: `paged_reg_if`

## Requirements
- R1: While address bit 5 is 0, the access targets the mode register, and address bits 4..0 have no effect on which register is reached.
- R2: The mode register is laid out as bit 7 = split, bit 6 = all-processor mode, bits 4..3 = memory select, bits 1..0 = stream. Bits 5 and 2 always read back as 0, and the register resets to 0x00.
- R3: While address bit 5 is 1 and split is 0, the memory request carries the target code from the memory select field (01 data memory, 10 connection low, 11 connection high) and the address {stream field, address bits 4..0}.
- R4: A page write while the target is the data memory issues no memory write. It is still acknowledged.
- R5: Connection high reads return only bits 2 and 0, with all other bits 0. Connection high writes send only bits 2 and 0, with all other bits 0.
- R6: While split is 1, every page read goes to the data memory and every page write goes to the connection low byte, whatever the memory select field holds.
- R7: Memory select 00 is reserved. Page reads then return 0x00, page writes change no memory, and no memory request is issued. Both are still acknowledged.
- R8: A mode register write drives the acknowledge low combinationally, as soon as chip select is low, strobe is high, address bit 5 is 0 and read/write is 0. No clock edge is needed.
- R9: A page access is acknowledged no earlier than SYNC_STAGES serial clocks after the strobe rises. Its memory request is issued only in a cycle where `proc_slot` is 1.
- R10: The acknowledge stays low while the strobe and chip select are held, and goes high as soon as either is released. One held strobe produces exactly one memory request.
- R11: Output `all_proc_mode` follows bit 6 of the mode register.
- R12: After reset, the acknowledge is high, no memory request is issued and `all_proc_mode` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_cs_n | input | 1 | Chip select, active low |
| bus_ds | input | 1 | Data strobe, active high |
| bus_rw | input | 1 | 1 = read, 0 = write |
| bus_addr | input | CH_BITS+1 | Bus address; top bit selects page versus mode register |
| bus_wdata | input | 8 | Write data from the processor |
| bus_rdata | output | 8 | Read data, valid while the acknowledge is low |
| bus_ack_n | output | 1 | Transfer acknowledge, active low |
| proc_slot | input | 1 | Marks the processor slot of the memory schedule |
| mem_req | output | 1 | One-cycle memory access request |
| mem_we | output | 1 | Request is a write |
| mem_tgt | output | 2 | Target memory code (01 data, 10 connection low, 11 connection high) |
| mem_addr | output | STRM_BITS+CH_BITS | {stream, channel} location |
| mem_wdata | output | 8 | Write data to memory |
| mem_rdata | input | 8 | Read data from the target, valid in the request cycle |
| all_proc_mode | output | 1 | Mode register bit 6 |

## Verification
The bench sweeps every stream and channel through both connection halves and the data memory. A page decode with swapped or dropped address bits would then return data from the wrong location. Split mode is set together with a conflicting memory select, so that a design which honours the select field would read the connection memory or write the wrong half. The bench also covers data memory writes and the reserved select code: the bench model catches a design that writes the data memory, and one that hangs would never acknowledge. The acknowledge itself is probed right after the strobe rises, while the strobe is held, and right after release. This separates a slow register write, a dropped hold and a lingering acknowledge.

// File: rtl/pri_pkg.sv
package pri_pkg;
   typedef enum logic [1:0] {
      TGT_RSVD = 2'b00,
      TGT_DM   = 2'b01,
      TGT_CML  = 2'b10,
      TGT_CMH  = 2'b11
   } tgt_e;

   localparam logic [7:0] MODE_RD_MASK = 8'hDB;
   localparam logic [7:0] CMH_MASK     = 8'h05;
   localparam int         SPLIT_BIT    = 7;
   localparam int         PE_BIT       = 6;
   localparam int         MSEL_HI      = 4;
   localparam int         MSEL_LO      = 3;
endpackage

// File: rtl/pri_sync.sv
module pri_sync #(
   parameter int WIDTH  = 2,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_i,
   input  logic [WIDTH-1:0] reset_val,
   output logic [WIDTH-1:0] sync_o
);
   logic [WIDTH-1:0] chain [STAGES];

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            chain[g] <= reset_val;
         end else if (g == 0) begin
            chain[g] <= async_i;
         end else begin
            chain[g] <= chain[(g == 0) ? 0 : g-1];
         end
      end
   end

   assign sync_o = chain[STAGES-1];
endmodule

// File: rtl/pri_page_dec.sv
module pri_page_dec
   import pri_pkg::*;
(
   input  logic [7:0] mode_q,
   input  logic       is_read,
   output tgt_e       tgt,
   output logic       do_req,
   output logic [7:0] rd_mask,
   output logic [7:0] wr_mask
);
   always_comb begin
      if (mode_q[SPLIT_BIT]) begin
         tgt = is_read ? TGT_DM : TGT_CML;
      end else begin
         tgt = tgt_e'(mode_q[MSEL_HI:MSEL_LO]);
      end
      do_req  = (tgt != TGT_RSVD) && !(!is_read && (tgt == TGT_DM));
      rd_mask = (tgt == TGT_CMH) ? CMH_MASK :
                (tgt == TGT_RSVD) ? 8'h00 : 8'hFF;
      wr_mask = (tgt == TGT_CMH) ? CMH_MASK : 8'hFF;
   end
endmodule

// File: rtl/pri_bus_fsm.sv
module pri_bus_fsm
   import pri_pkg::*;
#(
   parameter int CH_BITS   = 5,
   parameter int STRM_BITS = 2
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         act_s,
   input  logic                         bus_rw,
   input  logic [CH_BITS:0]             bus_addr,
   input  logic [7:0]                   bus_wdata,
   input  logic                         proc_slot,
   input  tgt_e                         tgt,
   input  logic                         do_req,
   input  logic [7:0]                   rd_mask,
   input  logic [7:0]                   wr_mask,
   input  logic [7:0]                   mem_rdata,
   output logic [7:0]                   mode_q,
   output logic                         cap_rw,
   output logic                         hold_ack,
   output logic                         mem_req,
   output logic                         mem_we,
   output logic [1:0]                   mem_tgt,
   output logic [STRM_BITS+CH_BITS-1:0] mem_addr,
   output logic [7:0]                   mem_wdata,
   output logic [7:0]                   rdata_q
);
   typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_HOLD} st_e;

   st_e              st_q;
   logic             act_prev;
   logic [CH_BITS:0] cap_addr;
   logic [7:0]       cap_wdata;
   logic             start;
   logic             slot_go;

   assign start   = act_s && !act_prev && (st_q == ST_IDLE);
   assign slot_go = (st_q == ST_WAIT) && proc_slot;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= ST_IDLE;
         act_prev  <= 1'b0;
         cap_addr  <= '0;
         cap_wdata <= '0;
         cap_rw    <= 1'b1;
         mode_q    <= '0;
         rdata_q   <= '0;
      end else begin
         act_prev <= act_s;
         case (st_q)
            ST_IDLE: begin
               if (start) begin
                  cap_addr  <= bus_addr;
                  cap_wdata <= bus_wdata;
                  cap_rw    <= bus_rw;
                  if (!bus_addr[CH_BITS]) begin
                     if (bus_rw) rdata_q <= mode_q & MODE_RD_MASK;
                     else        mode_q  <= bus_wdata;
                     st_q <= ST_HOLD;
                  end else begin
                     st_q <= ST_WAIT;
                  end
               end
            end
            ST_WAIT: begin
               if (proc_slot) begin
                  if (cap_rw) rdata_q <= do_req ? (mem_rdata & rd_mask) : 8'h00;
                  st_q <= ST_HOLD;
               end
            end
            default: begin
               if (!act_s) st_q <= ST_IDLE;
            end
         endcase
      end
   end

   assign hold_ack  = (st_q == ST_HOLD);
   assign mem_req   = slot_go && do_req;
   assign mem_we    = mem_req && !cap_rw;
   assign mem_tgt   = tgt;
   assign mem_addr  = {mode_q[STRM_BITS-1:0], cap_addr[CH_BITS-1:0]};
   assign mem_wdata = cap_wdata & wr_mask;
endmodule

// File: rtl/paged_reg_if.sv
module paged_reg_if
   import pri_pkg::*;
#(
   parameter int CH_BITS     = 5,
   parameter int STRM_BITS   = 2,
   parameter int SYNC_STAGES = 2,
   localparam int ADDR_W     = CH_BITS + 1,
   localparam int MADDR_W    = STRM_BITS + CH_BITS
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_cs_n,
   input  logic               bus_ds,
   input  logic               bus_rw,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [7:0]         bus_wdata,
   output logic [7:0]         bus_rdata,
   output logic               bus_ack_n,
   input  logic               proc_slot,
   output logic               mem_req,
   output logic               mem_we,
   output logic [1:0]         mem_tgt,
   output logic [MADDR_W-1:0] mem_addr,
   output logic [7:0]         mem_wdata,
   input  logic [7:0]         mem_rdata,
   output logic               all_proc_mode
);
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (STRM_BITS < 1 || STRM_BITS > 2) begin : g_bad_strm
      $error("STRM_BITS must fit the 2-bit stream field");
   end
   if (CH_BITS < 1 || CH_BITS > 8) begin : g_bad_ch
      $error("CH_BITS out of range");
   end

   logic [1:0] pins_s;
   logic       act_s;
   logic [7:0] cr_q;
   logic       cap_rw;
   logic       hold_ack;
   tgt_e       tgt;
   logic       do_req;
   logic [7:0] rd_mask;
   logic [7:0] wr_mask;
   logic       raw_act;
   logic       fast_wr;

   pri_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .async_i   ({bus_cs_n, bus_ds}),
      .reset_val (2'b10),
      .sync_o    (pins_s)
   );
   assign act_s = !pins_s[1] && pins_s[0];

   pri_page_dec u_dec (
      .mode_q  (cr_q),
      .is_read (cap_rw),
      .tgt     (tgt),
      .do_req  (do_req),
      .rd_mask (rd_mask),
      .wr_mask (wr_mask)
   );

   pri_bus_fsm #(.CH_BITS(CH_BITS), .STRM_BITS(STRM_BITS)) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .act_s     (act_s),
      .bus_rw    (bus_rw),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .proc_slot (proc_slot),
      .tgt       (tgt),
      .do_req    (do_req),
      .rd_mask   (rd_mask),
      .wr_mask   (wr_mask),
      .mem_rdata (mem_rdata),
      .mode_q    (cr_q),
      .cap_rw    (cap_rw),
      .hold_ack  (hold_ack),
      .mem_req   (mem_req),
      .mem_we    (mem_we),
      .mem_tgt   (mem_tgt),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .rdata_q   (bus_rdata)
   );

   assign raw_act       = !bus_cs_n && bus_ds;
   assign fast_wr       = !bus_addr[ADDR_W-1] && !bus_rw;
   assign bus_ack_n     = !(rst_n && raw_act && (fast_wr || hold_ack));
   assign all_proc_mode = cr_q[PE_BIT];
endmodule

// File: rtl/paged_reg_if_chk.sv
module paged_reg_if_chk #(
   parameter int CH_BITS   = 5,
   parameter int STRM_BITS = 2
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic                         bus_cs_n,
   input logic                         bus_ds,
   input logic                         bus_ack_n,
   input logic                         proc_slot,
   input logic                         mem_req,
   input logic                         mem_we,
   input logic [1:0]                   mem_tgt,
   input logic [STRM_BITS+CH_BITS-1:0] mem_addr,
   input logic [7:0]                   cr_q
);
   p_slot_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> proc_slot);

   p_no_dm_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |-> (mem_tgt != 2'b01));

   p_no_rsvd_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> (mem_tgt != 2'b00));

   p_split_route_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && cr_q[7]) |-> (mem_tgt == (mem_we ? 2'b10 : 2'b01)));

   p_page_route_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !cr_q[7]) |->
         (mem_tgt == cr_q[4:3]) &&
         (mem_addr[STRM_BITS+CH_BITS-1:CH_BITS] == cr_q[STRM_BITS-1:0]));

   p_single_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |=> !mem_req);

   p_ack_needs_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_cs_n || !bus_ds) |-> bus_ack_n);
endmodule

bind paged_reg_if paged_reg_if_chk #(.CH_BITS(CH_BITS), .STRM_BITS(STRM_BITS)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_cs_n  (bus_cs_n),
   .bus_ds    (bus_ds),
   .bus_ack_n (bus_ack_n),
   .proc_slot (proc_slot),
   .mem_req   (mem_req),
   .mem_we    (mem_we),
   .mem_tgt   (mem_tgt),
   .mem_addr  (mem_addr),
   .cr_q      (cr_q)
);

// File: tb/paged_reg_if_tb_top.sv
module paged_reg_if_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int NLOC       = 128;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_cs_n = 1'b1;
   logic       bus_ds = 1'b0;
   logic       bus_rw = 1'b1;
   logic [5:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       bus_ack_n;
   logic       proc_slot = 1'b0;
   logic       mem_req;
   logic       mem_we;
   logic [1:0] mem_tgt;
   logic [6:0] mem_addr;
   logic [7:0] mem_wdata;
   logic [7:0] mem_rdata;
   logic       all_proc_mode;

   logic [7:0] dm  [NLOC];
   logic [7:0] cml [NLOC];
   logic [7:0] cmh [NLOC];

   int checks = 0;
   int fails  = 0;
   int cycles = 0;
   int req_cnt = 0;
   int slot_cnt = 0;
   bit done = 0;

   paged_reg_if dut_i (
      .clk(clk), .rst_n(rst_n), .bus_cs_n(bus_cs_n), .bus_ds(bus_ds),
      .bus_rw(bus_rw), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .bus_ack_n(bus_ack_n), .proc_slot(proc_slot),
      .mem_req(mem_req), .mem_we(mem_we), .mem_tgt(mem_tgt),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .all_proc_mode(all_proc_mode)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(posedge clk) begin
      cycles <= cycles + 1;
      #2 proc_slot = (slot_cnt % 4 == 3);
      slot_cnt = slot_cnt + 1;
   end

   always_comb begin
      case (mem_tgt)
         2'b01:   mem_rdata = dm[mem_addr];
         2'b10:   mem_rdata = cml[mem_addr];
         2'b11:   mem_rdata = cmh[mem_addr];
         default: mem_rdata = 8'hEE;
      endcase
   end

   always @(negedge clk) begin
      if (rst_n && mem_req) begin
         req_cnt = req_cnt + 1;
         if (mem_we) begin
            if (mem_tgt == 2'b10) cml[mem_addr] = mem_wdata;
            else if (mem_tgt == 2'b11) cmh[mem_addr] = mem_wdata;
            else begin
               checks++; fails++;
               $display("FAIL R4/R7: write to target %0d act=1 exp=0", mem_tgt);
            end
         end
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: act=0x%0h exp=0x%0h", req, act, exp);
      end
   endtask

   task automatic acc(input bit rd, input logic [5:0] a, input logic [7:0] wd,
                      output logic [7:0] rdo, output int lat);
      @(negedge clk);
      bus_rw = rd; bus_addr = a; bus_wdata = wd; bus_cs_n = 1'b0;
      @(negedge clk);
      bus_ds = 1'b1;
      lat = 0;
      #1;
      while (bus_ack_n && lat < 200) begin
         @(negedge clk);
         lat++;
         #1;
      end
      if (lat >= 200) chk(0, "ack timeout", lat, 0);
      rdo = bus_rdata;
      repeat (3) @(negedge clk);
      bus_ds = 1'b0; bus_cs_n = 1'b1;
      repeat (5) @(negedge clk);
   endtask

   function automatic logic [7:0] mode(input bit sp, input bit pe,
                                       input logic [1:0] ms, input logic [1:0] st);
      return {sp, pe, 1'b0, ms, 1'b0, st};
   endfunction

   initial begin
      logic [7:0] r;
      int lat;
      int rc0;
      for (int i = 0; i < NLOC; i++) begin
         dm[i]  = 8'((i * 37 + 11) & 8'hFF);
         cml[i] = 8'h00;
         cmh[i] = 8'h00;
      end
      repeat (3) @(negedge clk);
      chk(bus_ack_n == 1'b1, "R12 ack in reset", bus_ack_n, 1);
      chk(mem_req == 1'b0, "R12 no req in reset", mem_req, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(all_proc_mode == 1'b0, "R12 pe after reset", all_proc_mode, 0);
      acc(1, 6'h00, 8'h00, r, lat);
      chk(r == 8'h00, "R12 mode reset value", r, 0);

      // R1/R2/R8/R11: write via one alias, read via another
      acc(0, 6'h1F, 8'hFF, r, lat);
      chk(lat == 0, "R8 fast mode write ack", lat, 0);
      chk(all_proc_mode == 1'b1, "R11 pe set", all_proc_mode, 1);
      acc(1, 6'h0A, 8'h00, r, lat);
      chk(r == 8'hDB, "R1 R2 mode readback", r, 8'hDB);
      acc(0, 6'h15, 8'h00, r, lat);
      chk(all_proc_mode == 1'b0, "R11 pe cleared", all_proc_mode, 0);

      // R3/R5 sweeps over all streams and channels
      for (int s = 0; s < 4; s++) begin
         acc(0, 6'h00, mode(0, 0, 2'b10, 2'(s)), r, lat);
         for (int c = 0; c < 32; c++)
            acc(0, 6'(32 + c), 8'(((s * 32 + c) * 5 + 1) & 8'hFF), r, lat);
         for (int c = 0; c < 32; c++) begin
            acc(1, 6'(32 + c), 8'h00, r, lat);
            chk(r == 8'(((s * 32 + c) * 5 + 1) & 8'hFF), "R3 conn low readback", r,
                ((s * 32 + c) * 5 + 1) & 8'hFF);
            chk(cml[s * 32 + c] == r, "R3 conn low location", cml[s * 32 + c], r);
         end
         acc(0, 6'h00, mode(0, 0, 2'b11, 2'(s)), r, lat);
         for (int c = 0; c < 32; c++)
            acc(0, 6'(32 + c), 8'(8'hFF ^ c), r, lat);
         for (int c = 0; c < 32; c++) begin
            acc(1, 6'(32 + c), 8'h00, r, lat);
            chk(r == ((8'hFF ^ c) & 8'h05), "R5 conn high readback", r, (8'hFF ^ c) & 8'h05);
            chk(cmh[s * 32 + c] == ((8'hFF ^ c) & 8'h05), "R5 conn high stored",
                cmh[s * 32 + c], (8'hFF ^ c) & 8'h05);
         end
         acc(0, 6'h00, mode(0, 0, 2'b01, 2'(s)), r, lat);
         for (int c = 0; c < 32; c++) begin
            acc(1, 6'(32 + c), 8'h00, r, lat);
            chk(r == dm[s * 32 + c], "R3 data memory read", r, dm[s * 32 + c]);
            if (c == 0) chk(lat >= 2, "R9 page ack latency", lat, 2);
         end
      end

      // R4: data memory writes ignored, still acknowledged
      acc(0, 6'h00, mode(0, 0, 2'b01, 2'd1), r, lat);
      rc0 = req_cnt;
      acc(0, 6'h27, 8'h00, r, lat);
      chk(lat < 200, "R4 dm write acknowledged", lat, 0);
      chk(req_cnt == rc0, "R4 no request for dm write", req_cnt - rc0, 0);
      acc(1, 6'h27, 8'h00, r, lat);
      chk(r == dm[39], "R4 dm unchanged", r, dm[39]);

      // R7: reserved select
      acc(0, 6'h00, mode(0, 0, 2'b00, 2'd0), r, lat);
      rc0 = req_cnt;
      acc(1, 6'h23, 8'h00, r, lat);
      chk(r == 8'h00, "R7 reserved read zero", r, 0);
      acc(0, 6'h23, 8'h77, r, lat);
      chk(req_cnt == rc0, "R7 no request", req_cnt - rc0, 0);
      acc(0, 6'h00, mode(0, 0, 2'b10, 2'd0), r, lat);
      acc(1, 6'h23, 8'h00, r, lat);
      chk(r == 8'((3 * 5 + 1) & 8'hFF), "R7 conn low untouched", r, 16);

      // R6: split mode with conflicting select
      acc(0, 6'h00, mode(1, 0, 2'b11, 2'd2), r, lat);
      acc(0, 6'h25, 8'h5A, r, lat);
      chk(cml[69] == 8'h5A, "R6 split write to conn low", cml[69], 8'h5A);
      chk(cmh[69] == ((8'hFF ^ 5) & 8'h05), "R6 conn high untouched", cmh[69], (8'hFF ^ 5) & 8'h05);
      acc(1, 6'h25, 8'h00, r, lat);
      chk(r == dm[69], "R6 split read from dm", r, dm[69]);
      acc(0, 6'h00, mode(0, 0, 2'b10, 2'd2), r, lat);
      acc(1, 6'h25, 8'h00, r, lat);
      chk(r == 8'h5A, "R6 split ended by mode write", r, 8'h5A);

      // R10: ack held and released, one request per strobe
      rc0 = req_cnt;
      @(negedge clk);
      bus_rw = 1'b1; bus_addr = 6'h21; bus_cs_n = 1'b0;
      @(negedge clk);
      bus_ds = 1'b1;
      repeat (20) @(negedge clk);
      #1 chk(bus_ack_n == 1'b0, "R10 ack held", bus_ack_n, 0);
      repeat (10) @(negedge clk);
      #1 chk(bus_ack_n == 1'b0, "R10 ack still held", bus_ack_n, 0);
      chk(req_cnt - rc0 == 1, "R10 single request", req_cnt - rc0, 1);
      bus_ds = 1'b0;
      #1 chk(bus_ack_n == 1'b1, "R10 ack released", bus_ack_n, 1);
      bus_cs_n = 1'b1;
      repeat (5) @(negedge clk);

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      wait (cycles > 150000);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: act=%0d exp<150000", cycles);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule